// File: doc/BRIEF.md
# ADC Conversion Autosequencer Controller

This controller walks a single shared analog-to-digital converter through a programmed list of conversion steps. Each step names one of sixteen input channels, and the converter's 12-bit answer for that step lands in the step's own result slot. The same channel may be listed in several steps, which gives an oversampling run. The steps can be run by two independent eight-step sequencers (A and B) or by one sixteen-step sequencer formed by cascading them.

A session starts on a trigger. For sequencer A the trigger is a software strobe, a PWM start event or an external pin. For sequencer B it is a software strobe or a second PWM event. A trigger that arrives while its sequencer is running is remembered and served once the running session ends. The converter is reached through a request/done handshake. Every end of session pulses the sequencer's interrupt, or only every second end if so configured. In start/stop mode, consecutive triggers convert successive groups of steps, with no rewind between them.

Configuration (mode, lengths, channel list) is supplied on input ports. It is expected to change only while both sequencers are idle, followed by a software reset.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A one-cycle pulse on `trig_sw1`, `trig_pwm_a` or `trig_ext` while sequencer A is idle sets `busy1` at the next clock edge.
- R2: With `cascade`=1, sequencer A runs `max_conv1`+1 conversions (1 to 16). Step i uses channel field `chan_list[4i+3:4i]` and writes result slot i. B triggers are ignored and `busy2` stays 0.
- R3: With `cascade`=0, A runs `max_conv1[2:0]`+1 steps on slots 0–7 and B runs `max_conv2`+1 steps on slots 8–15 (B step k uses field 8+k). A's channel is {0, field[2:0]} and B's channel is {1, field[2:0]}.
- R4: `conv_req` stays high until `conv_done` is seen, drops in the following cycle, and covers one conversion at a time. When both sequencers wait, A is served first and its whole session completes before B begins.
- R5: A trigger that arrives while its sequencer is busy is held. A second full session then follows the current one.
- R6: At each end of session the sequencer's `irq` line pulses for exactly one cycle. With `irq_every_other`=1, only the 2nd, 4th, … ends pulse it.
- R7: With `start_stop`=1, the step pointer is not rewound at the end of a session. The next trigger continues from the following step, wrapping modulo 16 (cascaded) or modulo 8 (dual).
- R8: With `start_stop`=0, every session starts at step 0.
- R9: `sw_reset1`/`sw_reset2` clear that sequencer's pointer, busy flag, held trigger and interrupt parity at the next edge, and abandon its in-flight request.
- R10: `rd_data` shows the 12-bit result slot addressed by `rd_addr`. The slot holds `conv_data` from the step that wrote it last.
- R11: After reset all results read 0, and `busy1`, `busy2`, `irq1`, `irq2` and `conv_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cascade | input | 1 | 1: one 16-step sequencer; 0: two 8-step sequencers |
| start_stop | input | 1 | Keep step pointer across sessions |
| irq_every_other | input | 1 | Interrupt on every second end of session |
| max_conv1 | input | 4 | Sequencer A session length minus one |
| max_conv2 | input | 3 | Sequencer B session length minus one |
| chan_list | input | 64 | Sixteen 4-bit channel fields, one per step |
| trig_sw1 | input | 1 | Software start, sequencer A |
| trig_pwm_a | input | 1 | PWM start event, sequencer A |
| trig_ext | input | 1 | External pin start, sequencer A |
| trig_sw2 | input | 1 | Software start, sequencer B |
| trig_pwm_b | input | 1 | PWM start event, sequencer B |
| sw_reset1 | input | 1 | Software reset of sequencer A |
| sw_reset2 | input | 1 | Software reset of sequencer B |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Multiplexer channel select |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 12 | Converter result |
| rd_addr | input | 4 | Result slot select |
| rd_data | output | 12 | Selected result |
| busy1 | output | 1 | Sequencer A session active |
| busy2 | output | 1 | Sequencer B session active |
| irq1 | output | 1 | Sequencer A end-of-session pulse |
| irq2 | output | 1 | Sequencer B end-of-session pulse |

## Verification
The assertions assume that `conv_done` is a single-cycle pulse given only while `conv_req` is high. They also assume that `cascade` changes only when sequencer B is idle. The bench's converter model raises `done` a fixed latency after each request, and it resets its delay whenever the request is withdrawn. The bench changes mode, lengths and channel list only after both sequencers have settled. Before any start/stop run it issues a software reset.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DATA_W = 12,
  parameter int HALF   = 8,
  localparam int STEPS = 2 * HALF,
  localparam int PW    = $clog2(STEPS),
  localparam int HW    = $clog2(HALF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cascade,
  input  logic              start_stop,
  input  logic              irq_every_other,
  input  logic [PW-1:0]     max_conv1,
  input  logic [HW-1:0]     max_conv2,
  input  logic [STEPS*PW-1:0] chan_list,
  input  logic              trig_sw1,
  input  logic              trig_pwm_a,
  input  logic              trig_ext,
  input  logic              trig_sw2,
  input  logic              trig_pwm_b,
  input  logic              sw_reset1,
  input  logic              sw_reset2,
  output logic              conv_req,
  output logic [PW-1:0]     conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [PW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy1,
  output logic              busy2,
  output logic              irq1,
  output logic              irq2
);

  logic [PW-1:0] ptr1, cnt1, last1, nxt1, slot, fld;
  logic [HW-1:0] ptr2, cnt2, nxt2;
  logic pend1, pend2, par1, par2, owner;
  logic [DATA_W-1:0] res [STEPS];

  wire go1  = trig_sw1 | trig_pwm_a | trig_ext;
  wire go2  = ~cascade & (trig_sw2 | trig_pwm_b);
  wire fin  = conv_req & conv_done;
  wire done1 = fin & ~owner;
  wire done2 = fin & owner;
  wire eos1 = done1 && (cnt1 == last1);
  wire eos2 = done2 && (cnt2 == max_conv2);

  assign last1 = cascade ? max_conv1 : {1'b0, max_conv1[HW-1:0]};
  assign nxt1  = cascade ? ptr1 + PW'(1) : {1'b0, ptr1[HW-1:0] + HW'(1)};
  assign nxt2  = ptr2 + HW'(1);
  assign slot  = owner ? {1'b1, ptr2} : ptr1;
  assign fld   = chan_list[slot*PW +: PW];
  assign conv_chan = cascade ? fld : {owner, fld[HW-1:0]};
  assign rd_data = res[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr1 <= '0; cnt1 <= '0; busy1 <= 1'b0; pend1 <= 1'b0; par1 <= 1'b0; irq1 <= 1'b0;
    end else if (sw_reset1) begin
      ptr1 <= '0; cnt1 <= '0; busy1 <= 1'b0; pend1 <= 1'b0; par1 <= 1'b0; irq1 <= 1'b0;
    end else begin
      irq1 <= 1'b0;
      if (eos1) begin
        cnt1  <= '0;
        ptr1  <= start_stop ? nxt1 : '0;
        busy1 <= pend1 | go1;
        pend1 <= pend1 & go1;
        irq1  <= ~irq_every_other | par1;
        par1  <= irq_every_other & ~par1;
      end else begin
        if (done1) begin
          cnt1 <= cnt1 + PW'(1);
          ptr1 <= nxt1;
        end
        if (go1) begin
          if (busy1) pend1 <= 1'b1;
          else       busy1 <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr2 <= '0; cnt2 <= '0; busy2 <= 1'b0; pend2 <= 1'b0; par2 <= 1'b0; irq2 <= 1'b0;
    end else if (sw_reset2) begin
      ptr2 <= '0; cnt2 <= '0; busy2 <= 1'b0; pend2 <= 1'b0; par2 <= 1'b0; irq2 <= 1'b0;
    end else begin
      irq2 <= 1'b0;
      if (eos2) begin
        cnt2  <= '0;
        ptr2  <= start_stop ? nxt2 : '0;
        busy2 <= pend2 | go2;
        pend2 <= pend2 & go2;
        irq2  <= ~irq_every_other | par2;
        par2  <= irq_every_other & ~par2;
      end else begin
        if (done2) begin
          cnt2 <= cnt2 + HW'(1);
          ptr2 <= nxt2;
        end
        if (go2) begin
          if (busy2) pend2 <= 1'b1;
          else       busy2 <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_req <= 1'b0;
      owner    <= 1'b0;
    end else if (conv_req) begin
      if (fin || (sw_reset1 && !owner) || (sw_reset2 && owner)) conv_req <= 1'b0;
    end else if (busy1 && !sw_reset1) begin
      conv_req <= 1'b1;
      owner    <= 1'b0;
    end else if (busy2 && !cascade && !sw_reset2) begin
      conv_req <= 1'b1;
      owner    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STEPS; i++) res[i] <= '0;
    end else if (fin) begin
      res[slot] <= conv_data;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cascade,
  input logic          sw_reset1,
  input logic          sw_reset2,
  input logic          conv_req,
  input logic          conv_done,
  input logic [PW-1:0] conv_chan,
  input logic          owner,
  input logic          busy1,
  input logic          busy2,
  input logic          irq1,
  input logic          irq2
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done && !sw_reset1 && !sw_reset2 |=> conv_req);

  // R4
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_done |=> !conv_req);

  // R3
  chan_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !cascade |-> conv_chan[PW-1] == owner);

  // R2
  no_seq2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade && !busy2 |=> !busy2);

  // R6
  irq1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |=> !irq1);

  // R6
  irq2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq2 |=> !irq2);

  // R6
  irq1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> $past(busy1));

  // R9
  sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset1 |=> !busy1);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .cascade(cascade),
  .sw_reset1(sw_reset1), .sw_reset2(sw_reset2),
  .conv_req(conv_req), .conv_done(conv_done), .conv_chan(conv_chan),
  .owner(owner), .busy1(busy1), .busy2(busy2), .irq1(irq1), .irq2(irq2)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cascade = 1'b1, start_stop = 1'b0, irq_every_other = 1'b0;
  logic [3:0] max_conv1 = '0;
  logic [2:0] max_conv2 = '0;
  logic [63:0] chan_list = '0;
  logic trig_sw1 = 0, trig_pwm_a = 0, trig_ext = 0, trig_sw2 = 0, trig_pwm_b = 0;
  logic sw_reset1 = 0, sw_reset2 = 0;
  logic conv_req, conv_done;
  logic [3:0] conv_chan, rd_addr;
  logic [11:0] conv_data, rd_data;
  logic busy1, busy2, irq1, irq2;

  int n_chk = 0, n_err = 0;
  int nconv = 0, irqc1 = 0, irqc2 = 0, dly = 0;
  logic [3:0] chlog [1024];

  always #5 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cascade(cascade), .start_stop(start_stop),
    .irq_every_other(irq_every_other), .max_conv1(max_conv1), .max_conv2(max_conv2),
    .chan_list(chan_list), .trig_sw1(trig_sw1), .trig_pwm_a(trig_pwm_a),
    .trig_ext(trig_ext), .trig_sw2(trig_sw2), .trig_pwm_b(trig_pwm_b),
    .sw_reset1(sw_reset1), .sw_reset2(sw_reset2), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy1(busy1), .busy2(busy2),
    .irq1(irq1), .irq2(irq2)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done <= 1'b0; conv_data <= '0; dly <= 0;
    end else if (conv_req && !conv_done) begin
      if (dly == LAT - 1) begin
        conv_done <= 1'b1;
        conv_data <= {conv_chan, nconv[7:0]};
        chlog[nconv % 1024] <= conv_chan;
        nconv <= nconv + 1;
        dly <= 0;
      end else dly <= dly + 1;
    end else begin
      conv_done <= 1'b0;
      dly <= 0;
    end
    if (irq1) irqc1 <= irqc1 + 1;
    if (irq2) irqc2 <= irqc2 + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fld(input int i);
    return int'(chan_list[i*4 +: 4]);
  endfunction

  task automatic fire1(input int src);
    @(negedge clk);
    case (src % 3)
      0: trig_sw1 = 1'b1;
      1: trig_pwm_a = 1'b1;
      default: trig_ext = 1'b1;
    endcase
    @(negedge clk);
    trig_sw1 = 0; trig_pwm_a = 0; trig_ext = 0;
  endtask

  task automatic settle();
    int q = 0;
    for (int i = 0; i < 4000 && q < 3; i++) begin
      @(negedge clk);
      if (!busy1 && !busy2 && !conv_req) q++; else q = 0;
    end
  endtask

  task automatic srst1();
    @(negedge clk); sw_reset1 = 1'b1;
    @(negedge clk); sw_reset1 = 1'b0;
  endtask

  task automatic srst2();
    @(negedge clk); sw_reset2 = 1'b1;
    @(negedge clk); sw_reset2 = 1'b0;
  endtask

  function automatic int rd(input int a);
    return 0;
  endfunction

  task automatic read_slot(input int a, output int v);
    @(negedge clk);
    rd_addr = 4'(a);
    #1 v = int'(rd_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int base, ib1, ib2, v;
    rd_addr = '0;
    for (int i = 0; i < 16; i++) chan_list[i*4 +: 4] = 4'(15 - i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 busy1", int'(busy1), 0);
    chk("R11 busy2", int'(busy2), 0);
    chk("R11 irq", int'(irq1 | irq2), 0);
    chk("R11 conv_req", int'(conv_req), 0);
    for (int a = 0; a < 16; a++) begin
      read_slot(a, v);
      chk("R11 R10 result zero", v, 0);
    end

    // R1 busy rises the edge after a trigger; R2 full 16-step cascade
    max_conv1 = 4'd15;
    base = nconv; ib1 = irqc1;
    @(negedge clk); trig_sw1 = 1'b1;
    @(negedge clk); trig_sw1 = 1'b0;
    chk("R1 busy1 after trigger", int'(busy1), 1);
    settle();
    chk("R2 conversions", nconv - base, 16);
    chk("R6 irq count", irqc1 - ib1, 1);
    for (int i = 0; i < 16; i++) begin
      read_slot(i, v);
      chk("R2 R10 slot channel", v >> 8, 15 - i);
      chk("R10 slot order", v & 255, (base + i) & 255);
    end

    // R2 R8 R1 sweep of session length, all trigger sources
    for (int m = 0; m < 16; m++) begin
      max_conv1 = 4'(m);
      base = nconv; ib1 = irqc1;
      fire1(m);
      settle();
      chk("R2 length sweep", nconv - base, m + 1);
      chk("R6 one irq per session", irqc1 - ib1, 1);
      for (int k = 0; k <= m; k++)
        chk("R8 restart at step 0", int'(chlog[(base + k) % 1024]), 15 - k);
    end

    // R2 sequencer B triggers ignored when cascaded
    base = nconv;
    @(negedge clk); trig_sw2 = 1'b1; trig_pwm_b = 1'b1;
    @(negedge clk); trig_sw2 = 1'b0; trig_pwm_b = 1'b0;
    chk("R2 busy2 stays low", int'(busy2), 0);
    repeat (20) @(negedge clk);
    chk("R2 no conversion from B", nconv - base, 0);

    // R3 R4 dual mode exhaustive length sweep, simultaneous triggers
    cascade = 1'b0;
    for (int i = 0; i < 16; i++) chan_list[i*4 +: 4] = 4'((i * 5 + 3) % 16);
    srst1(); srst2();
    for (int m1 = 0; m1 < 8; m1++) begin
      for (int m2 = 0; m2 < 8; m2++) begin
        max_conv1 = 4'(m1 + 8);
        max_conv2 = 3'(m2);
        base = nconv; ib1 = irqc1; ib2 = irqc2;
        @(negedge clk); trig_sw1 = 1'b1; trig_pwm_b = 1'b1;
        @(negedge clk); trig_sw1 = 1'b0; trig_pwm_b = 1'b0;
        settle();
        chk("R3 dual total", nconv - base, m1 + m2 + 2);
        chk("R6 irq1 dual", irqc1 - ib1, 1);
        chk("R6 irq2 dual", irqc2 - ib2, 1);
        for (int k = 0; k <= m1; k++)
          chk("R4 R3 A first, own group", int'(chlog[(base + k) % 1024]), fld(k) & 7);
        for (int k = 0; k <= m2; k++)
          chk("R4 R3 B after A, own group", int'(chlog[(base + m1 + 1 + k) % 1024]), 8 | (fld(8 + k) & 7));
      end
    end
    for (int k = 0; k < 8; k++) begin
      read_slot(8 + k, v);
      chk("R3 B result slot", v >> 8, 8 | (fld(8 + k) & 7));
    end

    // R5 held trigger, cascaded
    cascade = 1'b1;
    for (int i = 0; i < 16; i++) chan_list[i*4 +: 4] = 4'(15 - i);
    srst1(); srst2();
    max_conv1 = 4'd3;
    base = nconv; ib1 = irqc1;
    fire1(0);
    repeat (2) @(negedge clk);
    fire1(2);
    settle();
    chk("R5 two sessions", nconv - base, 8);
    chk("R5 two irqs", irqc1 - ib1, 2);
    for (int k = 0; k < 8; k++)
      chk("R5 second session from step 0", int'(chlog[(base + k) % 1024]), 15 - (k % 4));

    // R6 every other end of session
    irq_every_other = 1'b1;
    max_conv1 = 4'd1;
    ib1 = irqc1;
    for (int s = 1; s <= 4; s++) begin
      fire1(s);
      settle();
      chk("R6 every-other irq", irqc1 - ib1, s / 2);
    end
    irq_every_other = 1'b0;

    // R7 start/stop cascaded, wrap at 16
    start_stop = 1'b1;
    max_conv1 = 4'd2;
    srst1();
    base = nconv; ib1 = irqc1;
    for (int s = 0; s < 6; s++) begin
      fire1(s);
      settle();
    end
    chk("R7 irq per group", irqc1 - ib1, 6);
    for (int j = 0; j < 18; j++)
      chk("R7 continue and wrap", int'(chlog[(base + j) % 1024]), 15 - (j % 16));

    // R9 software reset rewinds the pointer
    srst1();
    base = nconv;
    fire1(0);
    settle();
    for (int k = 0; k < 3; k++)
      chk("R9 pointer rewound", int'(chlog[(base + k) % 1024]), 15 - k);

    // R7 start/stop dual, sequencer B wraps at 8
    cascade = 1'b0;
    max_conv2 = 3'd2;
    srst1(); srst2();
    base = nconv;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); trig_sw2 = 1'b1;
      @(negedge clk); trig_sw2 = 1'b0;
      settle();
    end
    for (int j = 0; j < 12; j++)
      chk("R7 B wraps mod 8", int'(chlog[(base + j) % 1024]), 8 | (fld(8 + (j % 8)) & 7));

    // R9 reset mid-session clears busy and withdraws the request
    cascade = 1'b1;
    start_stop = 1'b0;
    max_conv1 = 4'd15;
    srst1(); srst2();
    fire1(1);
    repeat (4) @(negedge clk);
    sw_reset1 = 1'b1;
    @(negedge clk); sw_reset1 = 1'b0;
    chk("R9 busy1 cleared", int'(busy1), 0);
    chk("R9 request withdrawn", int'(conv_req), 0);
    repeat (5) @(negedge clk);
    chk("R9 stays idle", int'(busy1 | conv_req), 0);
    base = nconv;
    max_conv1 = 4'd1;
    fire1(0);
    settle();
    chk("R9 restart at step 0", int'(chlog[base % 1024]), 15);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule